// File: doc/BRIEF.md
# Double-Buffered Serial Byte Data Path

This block sits between a processor-facing data register and a serial bit engine. It moves 8-bit bytes in both directions. On the transmit side, a processor write goes into a holding (shadow) register. The byte moves into a transmit shift register as soon as that shifter is idle. The shifter then presents one bit per transmit strobe on the transmit pin, most significant bit first. On the receive side, bits enter a receive shift register on receive strobes. Each completed byte is copied into a receive holding register, which the processor reads.

Two flags report the buffer state. The transmit-empty flag is set when a byte leaves the holding register for the shifter, and cleared by a processor write. The receive-full flag is set when a byte lands in the receive holding register, and cleared by a processor read. If a byte completes while the previous one is still unread, the new byte overwrites it and a sticky overrun bit is raised. Bit timing is supplied from outside through the two strobes.

The receive bit source can be chosen at run time. Normally it is the external receive pin, with a selectable sense (inverted or normal). In loopback, it is the block's own transmit output, which lets faults on the bus be separated from faults in the block.

Top module: `byte_dbuf_path`

## Requirements
- R1: After reset, rx_full = 0, rx_overrun = 0, tx_empty = 1, tx_busy = 0, tx_pin = 0 (passive level), and cpu_rdata = 0.
- R2: A cycle with cpu_wr = 1 loads cpu_wdata into the transmit holding register and clears tx_empty at that clock edge.
- R3: When the holding register holds a byte and the shifter is idle, the next clock edge moves the byte into the shifter, sets tx_busy, and sets tx_empty.
- R4: While tx_busy = 1, tx_pin shows the shifter's bit 7 first and then the lower bits in order, advancing one bit per cycle with tx_bit_stb = 1. After the 8th strobe tx_busy falls and tx_pin returns to 0.
- R5: Each rx_bit_stb shifts the selected receive bit in, most significant bit first. The 8th strobe copies the completed byte to cpu_rdata and sets rx_full.
- R6: cpu_rd = 1 clears rx_full at that edge, unless a byte completes in the same cycle; in that case rx_full stays 1 and no overrun is raised.
- R7: A byte that completes while rx_full = 1 and cpu_rd = 0 overwrites cpu_rdata and sets rx_overrun. rx_overrun then stays 1 until reset, including across reads.
- R8: With loop_en = 0, the received bit is rx_pin when rx_pol = 1 (normal) and the inverse of rx_pin when rx_pol = 0 (inverted).
- R9: With loop_en = 1, the received bit is the current tx_pin value. rx_pin and rx_pol have no effect.
- R10: If a write lands in the same cycle as a holding-to-shifter transfer, the older byte goes to the shifter, the new byte stays in the holding register, and tx_empty reads 0 afterwards.
- R11: A byte written while the shifter is busy waits in the holding register. It is moved into the shifter on the first edge after the 8th strobe, which sets tx_empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Write strobe for the data register |
| cpu_wdata | input | 8 | Byte to transmit |
| cpu_rd | input | 1 | Read strobe for the data register |
| cpu_rdata | output | 8 | Receive holding register contents |
| tx_bit_stb | input | 1 | Advance transmit shifter by one bit |
| rx_bit_stb | input | 1 | Sample one receive bit |
| loop_en | input | 1 | 1 = receive from transmit output, 0 = from pin |
| rx_pol | input | 1 | Receive pin sense: 1 normal, 0 inverted |
| rx_pin | input | 1 | External receive pin |
| tx_pin | output | 1 | Serial transmit output |
| tx_empty | output | 1 | Transmit holding register free |
| tx_busy | output | 1 | Transmit shifter active |
| rx_full | output | 1 | Unread received byte present |
| rx_overrun | output | 1 | Sticky overrun indicator |

## Verification
Two pairs of functions can fall in the same clock edge. A processor write can coincide with the holding-to-shifter transfer, and a processor read can coincide with the completion of a received byte. The bench provokes the first case by writing again in exactly the cycle after a write to an idle shifter. It then checks that the earlier byte appears serially and the later byte follows, with tx_empty low in between. It provokes the second case by raising the read strobe on the 8th receive strobe, and expects rx_full to stay high with no overrun.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
    localparam int unsigned DBP_DATA_W = 8;
    localparam logic DBP_PASSIVE = 1'b0;

    typedef enum logic {
        SRC_PIN  = 1'b0,
        SRC_LOOP = 1'b1
    } dbp_src_e;
endpackage

// File: rtl/dbp_rx_select.sv
module dbp_rx_select
    import dbp_pkg::*;
(
    input  logic loop_en,
    input  logic rx_pol,
    input  logic rx_pin,
    input  logic tx_bit,
    output logic bit_out
);
    dbp_src_e src;
    logic     pin_bit;

    always_comb begin
        src     = loop_en ? SRC_LOOP : SRC_PIN;
        pin_bit = rx_pol ? rx_pin : ~rx_pin;
        case (src)
            SRC_LOOP: bit_out = tx_bit;
            default:  bit_out = pin_bit;
        endcase
    end
endmodule

// File: rtl/dbp_tx_path.sv
module dbp_tx_path
    import dbp_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              bit_stb,
    output logic              tx_bit,
    output logic              empty,
    output logic              busy
);
    localparam int unsigned CW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] shadow;
        logic              shadow_vld;
        logic [DATA_W-1:0] shifter;
        logic              busy;
        logic [CW-1:0]     cnt;
        logic              empty;
    } tx_state_t;

    tx_state_t state_d, state_q;
    logic      load;

    always_comb begin
        state_d = state_q;
        load    = !state_q.busy && state_q.shadow_vld;

        if (state_q.busy && bit_stb) begin
            state_d.shifter = {state_q.shifter[DATA_W-2:0], 1'b0};
            if (state_q.cnt == LAST) begin
                state_d.busy = 1'b0;
                state_d.cnt  = '0;
            end else begin
                state_d.cnt = state_q.cnt + CW'(1);
            end
        end

        if (load) begin
            state_d.shifter    = state_q.shadow;
            state_d.busy       = 1'b1;
            state_d.cnt        = '0;
            state_d.shadow_vld = 1'b0;
            state_d.empty      = 1'b1;
        end

        if (wr) begin
            state_d.shadow     = wdata;
            state_d.shadow_vld = 1'b1;
            state_d.empty      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.shadow     <= '0;
            state_q.shadow_vld <= 1'b0;
            state_q.shifter    <= '0;
            state_q.busy       <= 1'b0;
            state_q.cnt        <= '0;
            state_q.empty      <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign tx_bit = state_q.busy ? state_q.shifter[DATA_W-1] : DBP_PASSIVE;
    assign empty  = state_q.empty;
    assign busy   = state_q.busy;

    AST_WR_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !state_q.empty); // R2
    AST_LOAD_SETS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr) |=> (state_q.empty && state_q.busy)); // R3
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.busy |-> (state_q.cnt <= LAST)); // R4
    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.busy && bit_stb && state_q.cnt == LAST) |=> !state_q.busy); // R4
    AST_WAIT_IN_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && state_q.busy) |=> state_q.shadow_vld); // R11
endmodule

// File: rtl/dbp_rx_path.sv
module dbp_rx_path #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_stb,
    input  logic              rd,
    output logic [DATA_W-1:0] rdata,
    output logic              full,
    output logic              overrun
);
    localparam int unsigned CW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] shifter;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] shadow;
        logic              full;
        logic              ovr;
    } rx_state_t;

    rx_state_t         state_d, state_q;
    logic              done;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        state_d = state_q;
        done    = bit_stb && (state_q.cnt == LAST);
        shifted = {state_q.shifter[DATA_W-2:0], bit_in};

        if (bit_stb) begin
            state_d.shifter = shifted;
            state_d.cnt     = done ? '0 : state_q.cnt + CW'(1);
        end

        if (rd) begin
            state_d.full = 1'b0;
        end

        if (done) begin
            state_d.shadow = shifted;
            state_d.full   = 1'b1;
            if (state_q.full && !rd) begin
                state_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata   = state_q.shadow;
    assign full    = state_q.full;
    assign overrun = state_q.ovr;

    AST_DONE_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> state_q.full); // R5
    AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !done) |=> !state_q.full); // R6
    AST_OVR_ON_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && state_q.full && !rd) |=> state_q.ovr); // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.ovr |=> state_q.ovr); // R7
endmodule

// File: rtl/byte_dbuf_path.sv
module byte_dbuf_path
    import dbp_pkg::*;
#(
    parameter int unsigned DATA_W = DBP_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              tx_bit_stb,
    input  logic              rx_bit_stb,
    input  logic              loop_en,
    input  logic              rx_pol,
    input  logic              rx_pin,
    output logic              tx_pin,
    output logic              tx_empty,
    output logic              tx_busy,
    output logic              rx_full,
    output logic              rx_overrun
);
    logic tx_bit;
    logic rx_bit;

    dbp_tx_path #(.DATA_W(DATA_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cpu_wr),
        .wdata   (cpu_wdata),
        .bit_stb (tx_bit_stb),
        .tx_bit  (tx_bit),
        .empty   (tx_empty),
        .busy    (tx_busy)
    );

    dbp_rx_select u_sel (
        .loop_en (loop_en),
        .rx_pol  (rx_pol),
        .rx_pin  (rx_pin),
        .tx_bit  (tx_bit),
        .bit_out (rx_bit)
    );

    dbp_rx_path #(.DATA_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (rx_bit),
        .bit_stb (rx_bit_stb),
        .rd      (cpu_rd),
        .rdata   (cpu_rdata),
        .full    (rx_full),
        .overrun (rx_overrun)
    );

    assign tx_pin = tx_bit;

    AST_IDLE_PASSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> (tx_pin == DBP_PASSIVE)); // R4
endmodule

// File: tb/sim_byte_dbuf_path.sv
module sim_byte_dbuf_path;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_rd = 1'b0;
    logic [7:0] cpu_rdata;
    logic       tx_bit_stb = 1'b0;
    logic       rx_bit_stb = 1'b0;
    logic       loop_en = 1'b0;
    logic       rx_pol = 1'b1;
    logic       rx_pin = 1'b0;
    logic       tx_pin, tx_empty, tx_busy, rx_full, rx_overrun;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    byte_dbuf_path u0 (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .tx_bit_stb(tx_bit_stb),
        .rx_bit_stb(rx_bit_stb), .loop_en(loop_en), .rx_pol(rx_pol),
        .rx_pin(rx_pin), .tx_pin(tx_pin), .tx_empty(tx_empty),
        .tx_busy(tx_busy), .rx_full(rx_full), .rx_overrun(rx_overrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cpu_wr = 0; cpu_rd = 0; tx_bit_stb = 0; rx_bit_stb = 0;
        loop_en = 0; rx_pol = 1; rx_pin = 0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic write_byte(input logic [7:0] b);
        cpu_wr = 1'b1; cpu_wdata = b;
        step();
        cpu_wr = 1'b0;
    endtask

    task automatic shift_tx_check(input string req, input logic [7:0] b);
        tx_bit_stb = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            chk(req, tx_pin, b[i]);
            step();
        end
        tx_bit_stb = 1'b0;
    endtask

    task automatic shift_rx(input logic [7:0] b, input logic pol, input logic rd_last);
        rx_bit_stb = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            rx_pin = pol ? b[i] : ~b[i];
            cpu_rd = (i == 0) && rd_last;
            step();
        end
        rx_bit_stb = 1'b0;
        cpu_rd = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 rx_full", rx_full, 0);
        chk("R1 rx_overrun", rx_overrun, 0);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 tx_busy", tx_busy, 0);
        chk("R1 tx_pin", tx_pin, 0);
        chk("R1 cpu_rdata", cpu_rdata, 0);
    endtask

    task automatic t_tx_basic();
        do_reset();
        write_byte(8'hA5);
        chk("R2 tx_empty after write", tx_empty, 0);
        chk("R2 not yet busy", tx_busy, 0);
        step();
        chk("R3 tx_empty after transfer", tx_empty, 1);
        chk("R3 tx_busy", tx_busy, 1);
        shift_tx_check("R4 serial bit", 8'hA5);
        chk("R4 busy falls", tx_busy, 0);
        chk("R4 passive pin", tx_pin, 0);
    endtask

    task automatic t_tx_wait();
        do_reset();
        write_byte(8'h3C);
        step();
        write_byte(8'hC3);
        chk("R11 empty low while waiting", tx_empty, 0);
        chk("R11 shifter busy", tx_busy, 1);
        shift_tx_check("R11 first byte bit", 8'h3C);
        chk("R11 still waiting", tx_empty, 0);
        step();
        chk("R11 second load empty", tx_empty, 1);
        chk("R11 second load busy", tx_busy, 1);
        shift_tx_check("R11 second byte bit", 8'hC3);
    endtask

    task automatic t_tx_collide();
        do_reset();
        write_byte(8'h5A);
        write_byte(8'h96);
        chk("R10 empty stays low", tx_empty, 0);
        chk("R10 busy", tx_busy, 1);
        shift_tx_check("R10 older byte bit", 8'h5A);
        step();
        chk("R10 newer byte loaded", tx_empty, 1);
        shift_tx_check("R10 newer byte bit", 8'h96);
    endtask

    task automatic t_rx_basic();
        do_reset();
        rx_pol = 1'b1;
        shift_rx(8'hB4, 1'b1, 1'b0);
        chk("R5 rx_full", rx_full, 1);
        chk("R5 rdata", cpu_rdata, 8'hB4);
        chk("R8 normal sense", cpu_rdata, 8'hB4);
        cpu_rd = 1'b1; step(); cpu_rd = 1'b0;
        chk("R6 read clears", rx_full, 0);
        rx_pol = 1'b0;
        shift_rx(8'h1E, 1'b0, 1'b0);
        chk("R8 inverted sense", cpu_rdata, 8'h1E);
        chk("R7 no overrun after read", rx_overrun, 0);
    endtask

    task automatic t_rx_collide();
        do_reset();
        shift_rx(8'h11, 1'b1, 1'b0);
        shift_rx(8'h22, 1'b1, 1'b1);
        chk("R6 completion wins", rx_full, 1);
        chk("R6 no overrun", rx_overrun, 0);
        chk("R6 rdata", cpu_rdata, 8'h22);
        shift_rx(8'h33, 1'b1, 1'b0);
        chk("R7 overrun set", rx_overrun, 1);
        chk("R7 overwritten", cpu_rdata, 8'h33);
        cpu_rd = 1'b1; step(); cpu_rd = 1'b0;
        chk("R7 full cleared", rx_full, 0);
        chk("R7 overrun sticky", rx_overrun, 1);
    endtask

    task automatic t_loop();
        do_reset();
        loop_en = 1'b1; rx_pol = 1'b0; rx_pin = 1'b1;
        write_byte(8'h6D);
        step();
        tx_bit_stb = 1'b1; rx_bit_stb = 1'b1;
        for (int i = 0; i < 8; i++) step();
        tx_bit_stb = 1'b0; rx_bit_stb = 1'b0;
        chk("R9 loop full", rx_full, 1);
        chk("R9 loop data", cpu_rdata, 8'h6D);
    endtask

    initial begin
        t_reset();
        t_tx_basic();
        t_tx_wait();
        t_tx_collide();
        t_rx_basic();
        t_rx_collide();
        t_loop();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule